// File: doc/BRIEF.md
# Lookup-Table ALU with Boot-Time Table Shadowing

This block is an 8-bit arithmetic unit that has no arithmetic gates of its own. Every operation, multiply and divide included, is one read of a function table. The table sits in a slow read-only memory. When reset is released, a sequencer copies the whole table, one word per clock, into a fast synchronous SRAM. After the copy, every request is served from the SRAM alone.

The read address joins an operation-select field with the two operands, laid out as `{op, a, b}`. The 16-bit table word comes back split in two. The low byte is the result. The high byte is the flags value, or the upper half of a product for multiply, or the remainder for divide.

While the copy runs, the block raises `busy` and holds `reqReady` low. A request held on the inputs during that time waits and is served once the copy ends. The operand width and the op-select width are parameters. With 8-bit operands and a 4- or 5-bit op field, the table address is 20 or 21 bits.

Top module: `talu_top`

## Requirements
- R1: While reset is asserted and in the first cycle after release, `busy` is 1, `reqReady` is 0 and `resValid` is 0.
- R2: The copy starts in the first cycle after reset release. It drives `romRdEn` high with `romAddr` equal to the cycle index: 0, 1, 2 and so on, up to the last table address.
- R3: The ROM has one cycle of read latency. The word read at address k is written to SRAM address k in the following cycle, with `sramWe` high and `sramWdata` equal to the ROM word.
- R4: With N table words, `busy` stays high for exactly N+1 cycles after reset release. It then stays low until the next reset.
- R5: `sramWe` is never high while `busy` is low.
- R6: A request is accepted on a clock edge where `reqValid` and `reqReady` are both high. The SRAM read address is `{reqOp, reqA, reqB}`, with op in the most significant bits and `reqB` in the least. In the next cycle `resValid` is 1, `result` holds bits 7:0 of the table word and `flags` holds bits 15:8.
- R7: A request held on the inputs while `busy` is high is not lost. It is accepted on the first edge with `busy` low, so its result appears N+2 cycles after reset release.
- R8: Requests on consecutive cycles produce results on consecutive cycles, in order, one cycle behind their requests.
- R9: The table word reaches the outputs unchanged. For the multiply operation (op 2) the high byte is the upper half of the product. For divide (op 3) the low byte is the quotient and the high byte is the remainder.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| romAddr | output | ADDR_W | Table ROM read address |
| romRdEn | output | 1 | Table ROM read enable |
| romData | input | 16 | ROM word, one cycle after its address |
| sramWe | output | 1 | SRAM write enable (copy only) |
| sramAddr | output | ADDR_W | SRAM address (write during copy, read afterwards) |
| sramWdata | output | 16 | SRAM write data |
| sramRdata | input | 16 | SRAM read word, one cycle after its address |
| reqValid | input | 1 | Operation request |
| reqOp | input | OP_W | Operation select |
| reqA | input | OPND_W | First operand |
| reqB | input | OPND_W | Second operand |
| reqReady | output | 1 | Requests may be accepted |
| busy | output | 1 | Boot copy in progress |
| resValid | output | 1 | Result of the previous cycle's request is present |
| result | output | 8 | Low byte of the table word |
| flags | output | 8 | High byte of the table word |

## Verification
The assertions assume two things about the outside world:
- the external ROM returns its word exactly one cycle after `romRdEn`;
- the SRAM presents read data one cycle after the address and is written only through this block.

The bench models both memories with that exact latency. It also keeps `reqValid` high across the whole boot, so the stall path is exercised under the conditions the assertions expect. Default parameters give a table too large to walk in a short run. The bench therefore narrows the operands to 3 bits. This keeps the address layout and the copy order the same but shrinks the table to 1024 words.

// File: rtl/talu_pkg.sv
package talu_pkg;

  typedef enum logic [1:0] {
    PH_COPY  = 2'd0,
    PH_DRAIN = 2'd1,
    PH_RUN   = 2'd2
  } phase_e;

  // Strobes from control to datapath
  typedef struct packed {
    logic stepRead;  // issue ROM read and advance the copy pointer
    logic runMode;   // serve requests from the SRAM
  } ctrl_s;

  localparam int WORD_W = 16;
  localparam int HALF_W = WORD_W / 2;

endpackage

// File: rtl/talu_ctrl.sv
module talu_ctrl
  import talu_pkg::*;
(
  input  logic  clk,
  input  logic  rstN,
  input  logic  lastRead,
  output ctrl_s ctrl,
  output logic  busy,
  output logic  reqReady
);

  phase_e phase, phaseNext;

  always_comb begin
    phaseNext = phase;
    unique case (phase)
      PH_COPY:  if (lastRead) phaseNext = PH_DRAIN;
      PH_DRAIN: phaseNext = PH_RUN;
      PH_RUN:   phaseNext = PH_RUN;
      default:  phaseNext = PH_COPY;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) phase <= PH_COPY;
    else       phase <= phaseNext;
  end

  always_comb begin
    ctrl.stepRead = (phase == PH_COPY);
    ctrl.runMode  = (phase == PH_RUN);
  end

  assign busy     = (phase != PH_RUN);
  assign reqReady = (phase == PH_RUN);

endmodule

// File: rtl/talu_datapath.sv
module talu_datapath
  import talu_pkg::*;
#(
  parameter int OPND_W = 8,
  parameter int OP_W   = 4,
  localparam int ADDR_W = OP_W + 2 * OPND_W
) (
  input  logic                clk,
  input  logic                rstN,
  input  ctrl_s               ctrl,
  output logic                lastRead,
  output logic [ADDR_W-1:0]   romAddr,
  output logic                romRdEn,
  input  logic [WORD_W-1:0]   romData,
  output logic                sramWe,
  output logic [ADDR_W-1:0]   sramAddr,
  output logic [WORD_W-1:0]   sramWdata,
  input  logic [WORD_W-1:0]   sramRdata,
  input  logic                reqValid,
  input  logic [OP_W-1:0]     reqOp,
  input  logic [OPND_W-1:0]   reqA,
  input  logic [OPND_W-1:0]   reqB,
  output logic                resValid,
  output logic [HALF_W-1:0]   result,
  output logic [HALF_W-1:0]   flags
);

  logic [ADDR_W-1:0] rdPtr;
  logic [ADDR_W-1:0] wrPtr;
  logic              wrPend;
  logic [ADDR_W-1:0] lookupAddr;

  // Copy read pointer
  always_ff @(posedge clk) begin
    if (!rstN)              rdPtr <= '0;
    else if (ctrl.stepRead) rdPtr <= rdPtr + ADDR_W'(1);
  end

  assign lastRead = (rdPtr == {ADDR_W{1'b1}});
  assign romAddr  = rdPtr;
  assign romRdEn  = ctrl.stepRead;

  // Write stage aligned to ROM latency
  always_ff @(posedge clk) begin
    if (!rstN) begin
      wrPend <= 1'b0;
      wrPtr  <= '0;
    end else begin
      wrPend <= ctrl.stepRead;
      wrPtr  <= rdPtr;
    end
  end

  assign lookupAddr = {reqOp, reqA, reqB};
  assign sramWe     = wrPend;
  assign sramWdata  = romData;
  assign sramAddr   = ctrl.runMode ? lookupAddr : wrPtr;

  // Result valid tracks accepted request
  always_ff @(posedge clk) begin
    if (!rstN) resValid <= 1'b0;
    else       resValid <= ctrl.runMode & reqValid;
  end

  assign result = sramRdata[HALF_W-1:0];
  assign flags  = sramRdata[WORD_W-1:HALF_W];

endmodule

// File: rtl/talu_top.sv
module talu_top
  import talu_pkg::*;
#(
  parameter int OPND_W = 8,
  parameter int OP_W   = 4,
  localparam int ADDR_W = OP_W + 2 * OPND_W
) (
  input  logic              clk,
  input  logic              rstN,
  output logic [ADDR_W-1:0] romAddr,
  output logic              romRdEn,
  input  logic [15:0]       romData,
  output logic              sramWe,
  output logic [ADDR_W-1:0] sramAddr,
  output logic [15:0]       sramWdata,
  input  logic [15:0]       sramRdata,
  input  logic              reqValid,
  input  logic [OP_W-1:0]   reqOp,
  input  logic [OPND_W-1:0] reqA,
  input  logic [OPND_W-1:0] reqB,
  output logic              reqReady,
  output logic              busy,
  output logic              resValid,
  output logic [7:0]        result,
  output logic [7:0]        flags
);

  ctrl_s ctrl;
  logic  lastRead;

  talu_ctrl u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .lastRead (lastRead),
    .ctrl     (ctrl),
    .busy     (busy),
    .reqReady (reqReady)
  );

  talu_datapath #(.OPND_W(OPND_W), .OP_W(OP_W)) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .ctrl      (ctrl),
    .lastRead  (lastRead),
    .romAddr   (romAddr),
    .romRdEn   (romRdEn),
    .romData   (romData),
    .sramWe    (sramWe),
    .sramAddr  (sramAddr),
    .sramWdata (sramWdata),
    .sramRdata (sramRdata),
    .reqValid  (reqValid),
    .reqOp     (reqOp),
    .reqA      (reqA),
    .reqB      (reqB),
    .resValid  (resValid),
    .result    (result),
    .flags     (flags)
  );

endmodule

// File: rtl/talu_chk.sv
module talu_chk #(
  parameter int ADDR_W = 20
) (
  input logic              clk,
  input logic              rstN,
  input logic [ADDR_W-1:0] romAddr,
  input logic              romRdEn,
  input logic              sramWe,
  input logic [ADDR_W-1:0] sramAddr,
  input logic              reqValid,
  input logic              reqReady,
  input logic              busy,
  input logic              resValid
);

  AST_ROM_STEP: assert property (@(posedge clk) disable iff (!rstN)
    (romRdEn && romAddr != '0) |-> (romAddr == $past(romAddr) + ADDR_W'(1))); // R2

  AST_WRITE_FOLLOWS_READ: assert property (@(posedge clk) disable iff (!rstN)
    sramWe |-> ($past(romRdEn) && sramAddr == $past(romAddr))); // R3

  AST_BUSY_STAYS_LOW: assert property (@(posedge clk) disable iff (!rstN)
    !busy |=> !busy); // R4

  AST_NO_WRITE_RUN: assert property (@(posedge clk) disable iff (!rstN)
    !busy |-> !sramWe); // R5

  AST_RESULT_AFTER_ACCEPT: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && reqReady) |=> resValid); // R6

  AST_RESULT_HAS_REQUEST: assert property (@(posedge clk) disable iff (!rstN)
    resValid |-> $past(reqValid && reqReady)); // R6

  AST_STALL_WHILE_BUSY: assert property (@(posedge clk) disable iff (!rstN)
    busy |-> !reqReady); // R7

endmodule

bind talu_top talu_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk      (clk),
  .rstN     (rstN),
  .romAddr  (romAddr),
  .romRdEn  (romRdEn),
  .sramWe   (sramWe),
  .sramAddr (sramAddr),
  .reqValid (reqValid),
  .reqReady (reqReady),
  .busy     (busy),
  .resValid (resValid)
);

// File: tb/sim_talu_top.sv
`timescale 1ns/1ps
module sim_talu_top;

  localparam int OPND_W = 3;
  localparam int OP_W   = 4;
  localparam int AW     = OP_W + 2 * OPND_W;
  localparam int N      = 1 << AW;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  always #2.5 clk = ~clk;

  logic [AW-1:0]     romAddr, sramAddr;
  logic              romRdEn, sramWe;
  logic [15:0]       romData, sramWdata, sramRdata;
  logic              reqValid = 1'b0;
  logic [OP_W-1:0]   reqOp = '0;
  logic [OPND_W-1:0] reqA = '0, reqB = '0;
  logic              reqReady, busy, resValid;
  logic [7:0]        result, flags;

  logic [15:0] rom [N];
  logic [15:0] mem [N];

  int nTests = 0;
  int nFail  = 0;
  int runWrites = 0;

  talu_top #(.OPND_W(OPND_W), .OP_W(OP_W)) u0 (
    .clk(clk), .rstN(rstN),
    .romAddr(romAddr), .romRdEn(romRdEn), .romData(romData),
    .sramWe(sramWe), .sramAddr(sramAddr), .sramWdata(sramWdata), .sramRdata(sramRdata),
    .reqValid(reqValid), .reqOp(reqOp), .reqA(reqA), .reqB(reqB),
    .reqReady(reqReady), .busy(busy), .resValid(resValid),
    .result(result), .flags(flags)
  );

  // Memory models: one cycle read latency
  always @(posedge clk) begin
    if (romRdEn) romData <= rom[romAddr];
  end
  always @(posedge clk) begin
    sramRdata <= mem[sramAddr];
    if (sramWe) mem[sramAddr] <= sramWdata;
  end
  always @(posedge clk) begin
    if (rstN && !busy && sramWe) runWrites++;
  end

  function automatic logic [15:0] tblWord(int idx);
    int op, a, b;
    op = idx >> (2 * OPND_W);
    a  = (idx >> OPND_W) & ((1 << OPND_W) - 1);
    b  = idx & ((1 << OPND_W) - 1);
    case (op)
      0: tblWord = {7'd0, (a + b) == 0, 8'(a + b)};
      1: tblWord = {6'd0, a < b, 1'b0, 8'(a - b)};
      2: tblWord = 16'(a * b * 1000);          // scaled product so the high half is used
      3: tblWord = (b == 0) ? {8'(a), 8'hFF} : {8'(a % b), 8'(a / b)};
      default: tblWord = 16'(idx * 40503) ^ 16'h5A5A;
    endcase
  endfunction

  function automatic int idxOf(int op, int a, int b);
    return (op << (2 * OPND_W)) | (a << OPND_W) | b;
  endfunction

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    nTests++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // R1, R2, R3, R4, R7: reset and boot copy, with a request held from reset
  task automatic testBoot();
    int badR2 = 0, badR3 = 0, badBusy = 0, badValid = 0, busyCycles = 0;
    int memBad = 0;
    reqValid = 1'b1; reqOp = 4'd2; reqA = 3'd5; reqB = 3'd6;
    repeat (3) @(negedge clk);
    #1;
    chk(busy && !reqReady && !resValid, "R1 reset outputs", {busy, reqReady, resValid}, 3'b100);
    @(negedge clk);
    rstN = 1'b1;
    #1;
    chk(busy && !reqReady && !resValid, "R1 first cycle", {busy, reqReady, resValid}, 3'b100);
    for (int c = 0; c <= N + 1; c++) begin
      if (c > 0) begin @(negedge clk); #1; end
      if (busy) busyCycles++;
      if (resValid) badValid++;
      if (c < N) begin
        if (!(romRdEn && romAddr == AW'(c))) badR2++;
      end else if (romRdEn) badR2++;
      if (c >= 1 && c <= N) begin
        if (!(sramWe && sramAddr == AW'(c - 1) && sramWdata == rom[c - 1])) badR3++;
      end else if (sramWe) badR3++;
    end
    chk(badR2 == 0, "R2 ROM walk mismatches", badR2, 0);
    chk(badR3 == 0, "R3 SRAM write mismatches", badR3, 0);
    chk(busyCycles == N + 1, "R4 busy cycles", busyCycles, N + 1);
    chk(!busy && reqReady, "R4 busy low after copy", busy, 0);
    chk(badValid == 0, "R7 no result during copy", badValid, 0);
    for (int i = 0; i < N; i++) if (mem[i] != rom[i]) memBad++;
    chk(memBad == 0, "R3 SRAM image", memBad, 0);
    @(negedge clk); #1;
    chk(resValid, "R7 held request served", resValid, 1);
    chk({flags, result} == tblWord(idxOf(2, 5, 6)), "R7 held request word",
        {flags, result}, tblWord(idxOf(2, 5, 6)));
    reqValid = 1'b0;
    @(negedge clk); #1;
    chk(!busy, "R4 busy stays low", busy, 0);
  endtask

  task automatic oneReq(input int op, input int a, input int b, input string req);
    reqValid = 1'b1; reqOp = OP_W'(op); reqA = OPND_W'(a); reqB = OPND_W'(b);
    @(negedge clk);
    reqValid = 1'b0;
    #1;
    chk(resValid, {req, " valid"}, resValid, 1);
    chk({flags, result} == tblWord(idxOf(op, a, b)), {req, " word"},
        {flags, result}, tblWord(idxOf(op, a, b)));
  endtask

  // R6: single requests with idle gap
  task automatic testSingle();
    oneReq(0, 3, 4, "R6 add");
    @(negedge clk); #1;
    chk(!resValid, "R6 idle no result", resValid, 0);
    oneReq(1, 2, 7, "R6 sub borrow");
    oneReq(15, 7, 7, "R6 top corner");
    oneReq(0, 0, 0, "R6 zero corner");
  endtask

  // R8: back-to-back stream
  task automatic testStream();
    int bad = 0;
    int prev = -1;
    for (int k = 0; k < 40; k++) begin
      int op = (k * 5) % 16, a = (k * 3) % 8, b = (k * 7 + 1) % 8;
      reqValid = 1'b1; reqOp = OP_W'(op); reqA = OPND_W'(a); reqB = OPND_W'(b);
      @(negedge clk); #1;
      if (!resValid || {flags, result} != tblWord(idxOf(op, a, b))) bad++;
      prev = k;
    end
    reqValid = 1'b0;
    chk(bad == 0 && prev == 39, "R8 stream mismatches", bad, 0);
  endtask

  // R9: multiply high half and divide remainder
  task automatic testMulDiv();
    oneReq(2, 7, 7, "R9 mul");
    chk(flags == 8'((7 * 7 * 1000) >> 8), "R9 mul high half", flags, 8'((7 * 7 * 1000) >> 8));
    oneReq(3, 7, 3, "R9 div");
    chk(result == 8'd2 && flags == 8'd1, "R9 quotient/remainder", {flags, result}, 16'h0102);
  endtask

  // R5: no writes in run mode
  task automatic testNoRunWrites();
    chk(runWrites == 0, "R5 writes after copy", runWrites, 0);
  endtask

  initial begin
    for (int i = 0; i < N; i++) begin
      rom[i] = tblWord(i);
      mem[i] = 16'hDEAD;
    end
    fork
      begin
        testBoot();
        testSingle();
        testStream();
        testMulDiv();
        testNoRunWrites();
      end
      begin
        repeat (20000) @(posedge clk);
        chk(1'b0, "watchdog", 0, 1);
      end
    join_any
    disable fork;
    $display("  [TB] %0d tests run, %0d failed", nTests, nFail);
    $finish;
  end

endmodule